// File: doc/BRIEF.md
# Thresholded Link Quality Indicator

This block turns an error estimate from a receiver's decision stage into a single link-quality flag. The estimate is a mean squared error value, supplied every clock cycle as an unsigned number. A two-bit selector picks one of four compare limits, each standing for a target bit-error rate. While the estimate stays at or below the selected limit, the flag is low.

When the estimate rises above the limit, the flag starts toggling with a fixed period. This warns that the link is degrading before it is lost. When the receiver reports that it has lost convergence and must retrain, the flag holds high.

The indicator is only meaningful in the phase-shift (DPSK) and quadrature-amplitude (QAM) operating modes. In every other mode the flag is forced low. The error estimator and the retrain sequencer sit outside this block.

Top module: `lqf_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `quality_flag` is 0 after that edge, and the block starts in the good state.
- R2: In a supported mode with `conv_lost` low, an estimate at or below the selected limit makes `quality_flag` 0 after the next rising edge.
- R3: `thr_sel` maps codes to limits as follows: 2'b00 selects `THR_E5` (the 1e-5 rate, the default), 2'b01 selects `THR_E6` (1e-6), 2'b10 selects `THR_E4` (1e-4), and 2'b11 selects `THR_E3` (1e-3). The limit is exceeded only when `mse_est` is strictly greater than it, compared unsigned.
- R4: When the limit is first exceeded (supported mode, `conv_lost` low), `quality_flag` is 1 after the next edge. While the excess persists, the flag inverts after every `TOGGLE_CYC` further edges.
- R5: The toggle period restarts on every entry into the toggling condition. The entry may come from the good state or from the lost state, and the first phase after each entry is always a full `TOGGLE_CYC` edges long with the flag high.
- R6: In a supported mode, `conv_lost` high makes `quality_flag` 1 after the next edge and keeps it 1 for as long as it stays high, whatever the estimate.
- R7: `link_mode` encodes 2'b00 as low-speed FSK, 2'b01 as DPSK, 2'b10 as QAM and 2'b11 as reserved. Only DPSK and QAM are supported. In the other two modes `quality_flag` is 0 after the next edge, whatever the estimate or `conv_lost`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mse_est | input | MSE_W | Unsigned mean squared error estimate |
| thr_sel | input | 2 | Error-rate limit selector |
| link_mode | input | 2 | Operating mode code |
| conv_lost | input | 1 | Receiver reports loss of convergence |
| quality_flag | output | 1 | Link quality flag (0 = acceptable) |

## Verification
The assertions assume that `mse_est`, `thr_sel`, `link_mode` and `conv_lost` are stable and known around each rising edge. They also assume that `TOGGLE_CYC` is at least 2, so that a toggle tick never coincides with an entry into the toggling state. The bench drives every input on the falling edge and samples the flag on the falling edge after the edge under test. It uses a short toggle period so that several full periods fit into each scenario. It also holds an input condition steady for the whole window in which a toggle sequence is being checked.

// File: rtl/lqf_pkg.sv
// Package: shared types for the link quality flag block.
// Assumes: mode codes are fixed by the surrounding receiver.
package lqf_pkg;

    typedef enum logic [1:0] {
        MODE_FSK  = 2'b00,
        MODE_DPSK = 2'b01,
        MODE_QAM  = 2'b10,
        MODE_RSVD = 2'b11
    } lqf_mode_e;

    typedef enum logic [1:0] {
        ST_GOOD   = 2'b00,
        ST_TOGGLE = 2'b01,
        ST_LOST   = 2'b10
    } lqf_state_e;

endpackage

// File: rtl/lqf_thr_cmp.sv
// Module: lqf_thr_cmp
// Compares the error estimate against four compile-time limits in
// parallel and selects one result with the two-bit code.
// Assumes: limits are unsigned and fit in MSE_W bits; purely combinational.
module lqf_thr_cmp #(
    parameter int unsigned MSE_W  = 16,
    parameter int unsigned THR_E5 = 200,
    parameter int unsigned THR_E6 = 100,
    parameter int unsigned THR_E4 = 400,
    parameter int unsigned THR_E3 = 800
) (
    input  logic [MSE_W-1:0] mse_est,
    input  logic [1:0]       thr_sel,
    output logic             exceed
);
    localparam int unsigned NUM_THR = 4;

    // Limit table indexed by selector code.
    localparam logic [MSE_W-1:0] LIMIT_TAB [NUM_THR] = '{
        MSE_W'(THR_E5), MSE_W'(THR_E6), MSE_W'(THR_E4), MSE_W'(THR_E3)
    };

    logic [NUM_THR-1:0] over_vec;

    // One unsigned strict comparator per limit.
    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_cmp
        assign over_vec[gi] = (mse_est > LIMIT_TAB[gi]);
    end

    // Pick the comparator named by the selector.
    always_comb begin
        exceed = over_vec[thr_sel];
    end

endmodule

// File: rtl/lqf_period_timer.sv
// Module: lqf_period_timer
// Counts clock cycles while the toggling state is active and pulses a
// tick every PERIOD cycles. It clears on restart and whenever idle.
// Assumes: PERIOD >= 2.
module lqf_period_timer #(
    parameter int unsigned PERIOD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick on the final count of each period while running.
    always_comb begin
        tick = run && (cnt_q == LAST);
    end

    // Cycle counter: cleared on reset, on restart, when idle, and at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lqf_state_ctl.sv
// Module: lqf_state_ctl
// Chooses between the good, toggling and lost states from the mode,
// the convergence report and the compare result, and drives the flag.
// Assumes: tick only arrives while in the toggling state.
module lqf_state_ctl
    import lqf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] link_mode,
    input  logic       conv_lost,
    input  logic       exceed,
    input  logic       tick,
    output logic       restart,
    output logic       in_toggle,
    output logic       flag
);
    lqf_state_e state_q, state_d;
    lqf_mode_e  mode_w;
    logic       mode_ok;

    // Decode which modes carry a valid indicator.
    always_comb begin
        mode_w  = lqf_mode_e'(link_mode);
        mode_ok = (mode_w == MODE_DPSK) || (mode_w == MODE_QAM);
    end

    // Next state: gating first, then convergence loss, then the compare.
    always_comb begin
        if (!mode_ok) begin
            state_d = ST_GOOD;
        end else if (conv_lost) begin
            state_d = ST_LOST;
        end else if (exceed) begin
            state_d = ST_TOGGLE;
        end else begin
            state_d = ST_GOOD;
        end
    end

    // Status toward the timer.
    always_comb begin
        in_toggle = (state_q == ST_TOGGLE);
        restart   = (state_d == ST_TOGGLE) && (state_q != ST_TOGGLE);
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GOOD;
            flag    <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_d)
                ST_LOST:   flag <= 1'b1;
                ST_TOGGLE: begin
                    if (state_q != ST_TOGGLE) begin
                        flag <= 1'b1;
                    end else if (tick) begin
                        flag <= ~flag;
                    end
                end
                default:   flag <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lqf_top.sv
// Module: lqf_top
// Link quality flag: a threshold compare, a state controller and a
// toggle period timer.
// Assumes: inputs synchronous to clk; TOGGLE_CYC >= 2.
module lqf_top #(
    parameter int unsigned MSE_W      = 16,
    parameter int unsigned TOGGLE_CYC = 40,
    parameter int unsigned THR_E5     = 200,
    parameter int unsigned THR_E6     = 100,
    parameter int unsigned THR_E4     = 400,
    parameter int unsigned THR_E3     = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSE_W-1:0] mse_est,
    input  logic [1:0]       thr_sel,
    input  logic [1:0]       link_mode,
    input  logic             conv_lost,
    output logic             quality_flag
);
    logic exceed_w;
    logic tick_w;
    logic restart_w;
    logic in_toggle_w;

    // Limit selection and compare.
    lqf_thr_cmp #(
        .MSE_W (MSE_W),
        .THR_E5(THR_E5),
        .THR_E6(THR_E6),
        .THR_E4(THR_E4),
        .THR_E3(THR_E3)
    ) u_cmp (
        .mse_est(mse_est),
        .thr_sel(thr_sel),
        .exceed (exceed_w)
    );

    // State and flag control.
    lqf_state_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_mode(link_mode),
        .conv_lost(conv_lost),
        .exceed   (exceed_w),
        .tick     (tick_w),
        .restart  (restart_w),
        .in_toggle(in_toggle_w),
        .flag     (quality_flag)
    );

    // Toggle period timer.
    lqf_period_timer #(
        .PERIOD(TOGGLE_CYC)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart_w),
        .run    (in_toggle_w),
        .tick   (tick_w)
    );

endmodule

// File: rtl/lqf_checker.sv
// Module: lqf_checker
// Assertions for lqf_top, attached by bind. Internal compare, tick and
// state signals are observed as produced by their own submodules.
// Assumes: inputs are known at every rising edge.
module lqf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] link_mode,
    input logic       conv_lost,
    input logic       exceed,
    input logic       tick,
    input logic       in_toggle,
    input logic       quality_flag
);
    logic mode_ok;

    // Supported-mode decode taken from the mode encoding.
    always_comb begin
        mode_ok = (link_mode == 2'b01) || (link_mode == 2'b10);
    end

    // R1: reset drives the flag low.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !quality_flag);

    // R2: within the limit, the flag is low.
    assert_good_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && !conv_lost && !exceed) |=> !quality_flag);

    // R4: entering the toggling condition raises the flag.
    assert_entry_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && !conv_lost && exceed && !in_toggle) |=> quality_flag);

    // R4: a tick while staying in toggling inverts the flag.
    assert_tick_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_toggle && tick && mode_ok && !conv_lost && exceed)
        |=> (quality_flag != $past(quality_flag)));

    // R5: between ticks the flag holds.
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_toggle && !tick && mode_ok && !conv_lost && exceed)
        |=> $stable(quality_flag));

    // R6: convergence loss holds the flag high.
    assert_lost_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && conv_lost) |=> quality_flag);

    // R7: unsupported modes force the flag low.
    assert_gated_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> !quality_flag);

endmodule

bind lqf_top lqf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_mode   (link_mode),
    .conv_lost   (conv_lost),
    .exceed      (exceed_w),
    .tick        (tick_w),
    .in_toggle   (in_toggle_w),
    .quality_flag(quality_flag)
);

// File: tb/sim_lqf_top.sv
// Directed bench for lqf_top: one task per scenario, each self-checking.
module sim_lqf_top;

    localparam int CLK_PERIOD = 10;
    localparam int MSE_W      = 12;
    localparam int PER        = 6;
    localparam int L_E5       = 200;
    localparam int L_E6       = 100;
    localparam int L_E4       = 400;
    localparam int L_E3       = 800;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [MSE_W-1:0] mse_est;
    logic [1:0]       thr_sel;
    logic [1:0]       link_mode;
    logic             conv_lost;
    logic             quality_flag;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    lqf_top #(
        .MSE_W     (MSE_W),
        .TOGGLE_CYC(PER),
        .THR_E5    (L_E5),
        .THR_E6    (L_E6),
        .THR_E4    (L_E4),
        .THR_E3    (L_E3)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mse_est     (mse_est),
        .thr_sel     (thr_sel),
        .link_mode   (link_mode),
        .conv_lost   (conv_lost),
        .quality_flag(quality_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One rising edge, then settle to the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int limit_of(input logic [1:0] code);
        case (code)
            2'b00:   return L_E5;
            2'b01:   return L_E6;
            2'b10:   return L_E4;
            default: return L_E3;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; mse_est = '0; thr_sel = 2'b00; link_mode = 2'b10; conv_lost = 1'b0;
        step();
        check("R1 reset low", quality_flag, 1'b0);
        mse_est = 12'd900;
        step();
        check("R1 reset holds low under excess", quality_flag, 1'b0);
        rst_n = 1'b1; mse_est = '0;
        step();
        check("R1 good after reset", quality_flag, 1'b0);
    endtask

    task automatic t_codes();
        link_mode = 2'b10;
        for (int c = 0; c < 4; c++) begin
            thr_sel = 2'(c);
            mse_est = MSE_W'(limit_of(2'(c)));
            step();
            check("R3/R2 equal is within limit", quality_flag, 1'b0);
            mse_est = MSE_W'(limit_of(2'(c)) + 1);
            step();
            check("R3 one above limit exceeds", quality_flag, 1'b1);
            mse_est = '0;
            step();
            check("R2 back within limit", quality_flag, 1'b0);
        end
        // Code 01 (lowest limit) distinguishes from code 00 at 150.
        thr_sel = 2'b01; mse_est = 12'd150;
        step();
        check("R3 code 01 uses 1e-6 limit", quality_flag, 1'b1);
        thr_sel = 2'b00;
        step();
        check("R3 code 00 uses 1e-5 limit", quality_flag, 1'b0);
        mse_est = '0;
        step();
    endtask

    task automatic t_toggle();
        link_mode = 2'b01; thr_sel = 2'b11; mse_est = 12'd1000;
        for (int k = 0; k < 3*PER; k++) begin
            step();
            check("R4 toggle pattern", quality_flag, ((k / PER) % 2) == 0);
        end
        mse_est = '0;
        step();
        check("R2 leave toggling", quality_flag, 1'b0);
    endtask

    task automatic t_restart();
        link_mode = 2'b10; thr_sel = 2'b10; mse_est = 12'd500;
        for (int k = 0; k < PER + 2; k++) step();
        check("R4 second phase low", quality_flag, 1'b0);
        mse_est = 12'd10;
        step();
        mse_est = 12'd500;
        for (int k = 0; k < PER; k++) begin
            step();
            check("R5 full high phase after reentry", quality_flag, 1'b1);
        end
        step();
        check("R5 falls after one period", quality_flag, 1'b0);
        mse_est = '0;
        step();
    endtask

    task automatic t_lost();
        link_mode = 2'b10; thr_sel = 2'b00; mse_est = 12'd300;
        for (int k = 0; k < PER + 1; k++) step();
        check("R4 low phase before loss", quality_flag, 1'b0);
        conv_lost = 1'b1;
        for (int k = 0; k < 2*PER + 1; k++) begin
            step();
            check("R6 held high on loss", quality_flag, 1'b1);
        end
        mse_est = '0;
        step();
        check("R6 high regardless of estimate", quality_flag, 1'b1);
        conv_lost = 1'b0; mse_est = 12'd300;
        for (int k = 0; k < PER; k++) begin
            step();
            check("R5 restart from lost state", quality_flag, 1'b1);
        end
        step();
        check("R5 period after lost state", quality_flag, 1'b0);
        mse_est = '0;
        step();
    endtask

    task automatic t_mode();
        thr_sel = 2'b00; mse_est = 12'd900; conv_lost = 1'b1; link_mode = 2'b10;
        step();
        check("R6 lost in QAM", quality_flag, 1'b1);
        link_mode = 2'b00;
        step();
        check("R7 FSK mode gates flag", quality_flag, 1'b0);
        conv_lost = 1'b0;
        step();
        check("R7 FSK ignores excess", quality_flag, 1'b0);
        link_mode = 2'b11;
        step();
        check("R7 reserved mode gates flag", quality_flag, 1'b0);
        conv_lost = 1'b1;
        step();
        check("R7 reserved ignores loss", quality_flag, 1'b0);
        conv_lost = 1'b0; link_mode = 2'b01;
        step();
        check("R7 DPSK supported", quality_flag, 1'b1);
        mse_est = '0;
        step();
        check("R2 DPSK within limit", quality_flag, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; mse_est = '0; thr_sel = '0; link_mode = '0; conv_lost = 1'b0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_toggle();
        t_restart();
        t_lost();
        t_mode();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule